// File: doc/BRIEF.md
# Bulk Bitwise Operation Command Sequencer

This block sits on the memory-controller side of a DRAM subarray that computes bitwise functions in place. A client hands it one request: an operation code, two source row addresses and one destination row address. The sequencer expands that request into a fixed, ordered list of row commands. Source data is cloned into a group of designated compute rows. A control row is preset from a reserved constant row. A single reserved row address fires a bitwise majority across the three compute rows. The result is then cloned out, through an inverting dual-contact row where the operation requires it.

Each command carries a kind (row copy or majority activation), a source row and a destination row. Commands leave through a valid/ready handshake, one at a time and in strict order. The request side accepts one request while idle and stalls further requests until the last command has been taken. A one-cycle done pulse marks the completion of each request.

Reserved rows sit at the top of the row address space. With `BASE = 2^ROW_W - 8`, the offsets are:

| Offset | Row |
|---|---|
| +0, +1, +2 | Compute rows T0, T1, T2 (T2 is the control row) |
| +3 | Dual-contact row, true side (DCC) |
| +4 | Dual-contact row, complement side (DCCN) |
| +5 | Constant all-zeros row (ZERO) |
| +6 | Constant all-ones row (ONE) |
| +7 | Majority trigger address (MAJ) |

Top module: `bbo_sequencer`

## Requirements
- R1: After reset, `busy`, `cmd_valid` and `done` are 0 and `req_ready` is 1.
- R2: Opcode 0 (AND) issues exactly these five commands: copy A->T0, copy B->T1, copy ZERO->T2, activate MAJ, copy T0->D.
- R3: Opcode 1 (OR) issues the same five commands as AND, except that the third command copies ONE->T2.
- R4: Opcode 2 (NOT) issues exactly two commands: copy A->DCC, then copy DCCN->D.
- R5: Opcodes 3 (NAND) and 4 (NOR) first issue the AND or OR sequence up to and including the activation. They then issue copy T0->DCC and copy DCCN->D, six commands in total.
- R6: Opcode 5 (XOR) issues thirteen commands, in this order:
  1. A->T0, B->T1, ZERO->T2, then activate MAJ.
  2. T0->DCC.
  3. A->T0, B->T1, ONE->T2, then activate MAJ.
  4. DCCN->T1, ZERO->T2, then activate MAJ.
  5. T0->D.
- R7: Every majority activation has `cmd_kind` = 1, `cmd_src` = MAJ (BASE+7) and `cmd_dst` = 0. Every copy has `cmd_kind` = 0.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command fields hold steady. The next command appears only after the current one has been accepted.
- R9: `req_ready` is low from the cycle after a request is accepted until the last command is accepted. A request presented during that time is ignored and does not change the command stream.
- R10: `done` is high for exactly one cycle, the cycle after the final command of a request is accepted.
- R11: Opcodes 6 and 7 run the AND sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 3 | Operation code (0 AND, 1 OR, 2 NOT, 3 NAND, 4 NOR, 5 XOR) |
| req_src_a | input | ROW_W | First source row |
| req_src_b | input | ROW_W | Second source row |
| req_dst | input | ROW_W | Destination row |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse after the final command is accepted |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_kind | output | 1 | 0 row copy, 1 majority activation |
| cmd_src | output | ROW_W | Copy source row, or MAJ for an activation |
| cmd_dst | output | ROW_W | Copy destination row, 0 for an activation |

## Verification
Each of the six operation codes is run, plus the two spare codes. Comparing the command streams of AND, OR, NAND and NOR separates the choice of constant row from the added inversion tail. XOR exercises reuse of the compute rows across three activations. Some runs use an always-ready command sink and others a pseudo-random stalling sink. This separates the ordering logic from the hold-under-backpressure behaviour. Requests injected mid-run and back-to-back requests separate correct stalling from accidental capture, and check that done pulses once.

// File: rtl/bbo_pkg.sv
// Package: shared encodings for the bulk bitwise command sequencer.
// Assumes reserved rows occupy the top eight row addresses.
package bbo_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_NOT  = 3'd2,
        OP_NAND = 3'd3,
        OP_NOR  = 3'd4,
        OP_XOR  = 3'd5
    } op_e;

    typedef enum logic {
        KIND_COPY = 1'b0,
        KIND_ACT  = 1'b1
    } kind_e;

    // Offsets of reserved rows above the reserved base address
    localparam int OFS_T0   = 0;
    localparam int OFS_T1   = 1;
    localparam int OFS_T2   = 2;
    localparam int OFS_DCC  = 3;
    localparam int OFS_DCCN = 4;
    localparam int OFS_ZERO = 5;
    localparam int OFS_ONE  = 6;
    localparam int OFS_MAJ  = 7;
    localparam int RSV_ROWS = 8;

    // Longest command program (XOR) and step index width
    localparam int SEQ_MAX = 13;
    localparam int STEP_W  = $clog2(SEQ_MAX);

endpackage

// File: rtl/bbo_step_ctr.sv
// Module: step index of the running command program.
// Assumes clear and adv are never high together; the index stays below SEQ_MAX.
module bbo_step_ctr
    import bbo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              adv,
    output logic [STEP_W-1:0] step
);

    // Reset, restart or advance the step index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (clear) begin
            step <= '0;
        end else if (adv) begin
            step <= step + 1'b1;
        end
    end

    assert_step_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step < STEP_W'(SEQ_MAX));

endmodule

// File: rtl/bbo_step_decode.sv
// Module: maps (operation, step index) onto one row command.
// Purely combinational; assumes the caller stops at the step flagged last.
module bbo_step_decode
    import bbo_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic [2:0]        op,
    input  logic [ROW_W-1:0]  row_a,
    input  logic [ROW_W-1:0]  row_b,
    input  logic [ROW_W-1:0]  row_d,
    input  logic [STEP_W-1:0] step,
    output kind_e             kind,
    output logic [ROW_W-1:0]  src,
    output logic [ROW_W-1:0]  dst,
    output logic              last
);

    localparam logic [ROW_W-1:0] BASE   = ROW_W'((1 << ROW_W) - RSV_ROWS);
    localparam logic [ROW_W-1:0] R_T0   = BASE + ROW_W'(OFS_T0);
    localparam logic [ROW_W-1:0] R_T1   = BASE + ROW_W'(OFS_T1);
    localparam logic [ROW_W-1:0] R_T2   = BASE + ROW_W'(OFS_T2);
    localparam logic [ROW_W-1:0] R_DCC  = BASE + ROW_W'(OFS_DCC);
    localparam logic [ROW_W-1:0] R_DCCN = BASE + ROW_W'(OFS_DCCN);
    localparam logic [ROW_W-1:0] R_ZERO = BASE + ROW_W'(OFS_ZERO);
    localparam logic [ROW_W-1:0] R_ONE  = BASE + ROW_W'(OFS_ONE);
    localparam logic [ROW_W-1:0] R_MAJ  = BASE + ROW_W'(OFS_MAJ);

    logic             use_one;
    logic             invert;
    logic [ROW_W-1:0] ctrl_row;

    // Pick the constant row and whether an inversion tail follows
    always_comb begin
        use_one  = (op == OP_OR) || (op == OP_NOR);
        invert   = (op == OP_NAND) || (op == OP_NOR);
        ctrl_row = use_one ? R_ONE : R_ZERO;
    end

    // Produce the command for the current step
    always_comb begin
        kind = KIND_COPY;
        src  = '0;
        dst  = '0;
        last = 1'b0;
        if (op == OP_NOT) begin
            if (step == 0) begin
                src = row_a;  dst = R_DCC;
            end else begin
                src = R_DCCN; dst = row_d; last = 1'b1;
            end
        end else if (op == OP_XOR) begin
            case (step)
                4'd0:    begin src = row_a;  dst = R_T0;  end
                4'd1:    begin src = row_b;  dst = R_T1;  end
                4'd2:    begin src = R_ZERO; dst = R_T2;  end
                4'd3:    begin kind = KIND_ACT; src = R_MAJ; end
                4'd4:    begin src = R_T0;   dst = R_DCC; end
                4'd5:    begin src = row_a;  dst = R_T0;  end
                4'd6:    begin src = row_b;  dst = R_T1;  end
                4'd7:    begin src = R_ONE;  dst = R_T2;  end
                4'd8:    begin kind = KIND_ACT; src = R_MAJ; end
                4'd9:    begin src = R_DCCN; dst = R_T1;  end
                4'd10:   begin src = R_ZERO; dst = R_T2;  end
                4'd11:   begin kind = KIND_ACT; src = R_MAJ; end
                default: begin src = R_T0;   dst = row_d; last = 1'b1; end
            endcase
        end else begin
            case (step)
                4'd0: begin src = row_a;    dst = R_T0; end
                4'd1: begin src = row_b;    dst = R_T1; end
                4'd2: begin src = ctrl_row; dst = R_T2; end
                4'd3: begin kind = KIND_ACT; src = R_MAJ; end
                4'd4: begin
                    src = R_T0;
                    if (invert) begin
                        dst = R_DCC;
                    end else begin
                        dst = row_d; last = 1'b1;
                    end
                end
                default: begin src = R_DCCN; dst = row_d; last = 1'b1; end
            endcase
        end
    end

endmodule

// File: rtl/bbo_sequencer.sv
// Module: top of the bulk bitwise command sequencer.
// Takes one request while idle, walks its command program through a
// valid/ready command port, then pulses done. Assumes cmd_ready may stall freely.
module bbo_sequencer
    import bbo_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [ROW_W-1:0] req_src_a,
    input  logic [ROW_W-1:0] req_src_b,
    input  logic [ROW_W-1:0] req_dst,
    output logic             busy,
    output logic             done,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic             cmd_kind,
    output logic [ROW_W-1:0] cmd_src,
    output logic [ROW_W-1:0] cmd_dst
);

    localparam logic [ROW_W-1:0] R_MAJ = ROW_W'((1 << ROW_W) - RSV_ROWS + OFS_MAJ);

    logic              busy_q;
    logic              done_q;
    logic [2:0]        op_q;
    logic [ROW_W-1:0]  a_q;
    logic [ROW_W-1:0]  b_q;
    logic [ROW_W-1:0]  d_q;
    logic [STEP_W-1:0] step;
    kind_e             dec_kind;
    logic              dec_last;
    logic              take;
    logic              fire;

    // Handshake events on both sides
    always_comb begin
        take = req_valid && !busy_q;
        fire = busy_q && cmd_ready;
    end

    // Busy and done flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= fire && dec_last;
            if (take) begin
                busy_q <= 1'b1;
            end else if (fire && dec_last) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Capture the request fields when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            d_q  <= '0;
        end else if (take) begin
            op_q <= req_op;
            a_q  <= req_src_a;
            b_q  <= req_src_b;
            d_q  <= req_dst;
        end
    end

    bbo_step_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (take),
        .adv   (fire && !dec_last),
        .step  (step)
    );

    bbo_step_decode #(.ROW_W(ROW_W)) u_dec (
        .op    (op_q),
        .row_a (a_q),
        .row_b (b_q),
        .row_d (d_q),
        .step  (step),
        .kind  (dec_kind),
        .src   (cmd_src),
        .dst   (cmd_dst),
        .last  (dec_last)
    );

    // Drive the remaining outputs
    always_comb begin
        req_ready = !busy_q;
        busy      = busy_q;
        done      = done_q;
        cmd_valid = busy_q;
        cmd_kind  = dec_kind;
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind)
                                       && $stable(cmd_src) && $stable(cmd_dst)));

    assert_act_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind) |-> (cmd_src == R_MAJ && cmd_dst == '0));

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && cmd_valid && !req_ready));

    assert_stay_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_ready) |=> busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid && cmd_ready));

endmodule

// File: tb/bbo_sequencer_bench.sv
// Bench: scoreboard of expected row commands against the command port.
module bbo_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RW = 10;
    localparam logic [RW-1:0] BASE = RW'((1 << RW) - 8);
    localparam logic [RW-1:0] T0 = BASE + 0, T1 = BASE + 1, T2 = BASE + 2;
    localparam logic [RW-1:0] DCC = BASE + 3, DCCN = BASE + 4;
    localparam logic [RW-1:0] ZERO = BASE + 5, ONE = BASE + 6, MAJ = BASE + 7;

    typedef struct {
        logic          kind;
        logic [RW-1:0] src;
        logic [RW-1:0] dst;
        logic          last;
        string         tag;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0;
    logic [2:0] req_op = 0;
    logic [RW-1:0] req_src_a = 0, req_src_b = 0, req_dst = 0;
    logic cmd_ready = 1;
    logic req_ready, busy, done, cmd_valid, cmd_kind;
    logic [RW-1:0] cmd_src, cmd_dst;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    bit   stall_en = 0;
    bit   finished = 0;
    logic [7:0] lfsr = 8'hA5;

    always #(CLK_PERIOD/2) clk = ~clk;

    bbo_sequencer #(.ROW_W(RW)) u_bbo_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_src_a(req_src_a), .req_src_b(req_src_b),
        .req_dst(req_dst), .busy(busy), .done(done), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic k, input logic [RW-1:0] s, input logic [RW-1:0] d,
                        input logic l, input string tag);
        exp_t e;
        e.kind = k; e.src = s; e.dst = d; e.last = l; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Expected command program for one request, built from the requirement text
    task automatic expect_prog(input logic [2:0] op, input logic [RW-1:0] a,
                               input logic [RW-1:0] b, input logic [RW-1:0] d);
        string tg;
        case (op)
            3'd1: tg = "R3"; 3'd2: tg = "R4"; 3'd3, 3'd4: tg = "R5";
            3'd5: tg = "R6"; 3'd6, 3'd7: tg = "R11"; default: tg = "R2";
        endcase
        if (op == 3'd2) begin
            push(0, a, DCC, 0, tg);
            push(0, DCCN, d, 1, tg);
        end else if (op == 3'd5) begin
            push(0, a, T0, 0, tg);    push(0, b, T1, 0, tg);
            push(0, ZERO, T2, 0, tg); push(1, MAJ, '0, 0, "R7");
            push(0, T0, DCC, 0, tg);
            push(0, a, T0, 0, tg);    push(0, b, T1, 0, tg);
            push(0, ONE, T2, 0, tg);  push(1, MAJ, '0, 0, "R7");
            push(0, DCCN, T1, 0, tg); push(0, ZERO, T2, 0, tg);
            push(1, MAJ, '0, 0, "R7");
            push(0, T0, d, 1, tg);
        end else begin
            push(0, a, T0, 0, tg);
            push(0, b, T1, 0, tg);
            push(0, (op == 3'd1 || op == 3'd4) ? ONE : ZERO, T2, 0, tg);
            push(1, MAJ, '0, 0, "R7");
            if (op == 3'd3 || op == 3'd4) begin
                push(0, T0, DCC, 0, tg);
                push(0, DCCN, d, 1, tg);
            end else begin
                push(0, T0, d, 1, tg);
            end
        end
    endtask

    // Driver: present one request, record its expected commands
    task automatic send(input logic [2:0] op, input logic [RW-1:0] a,
                        input logic [RW-1:0] b, input logic [RW-1:0] d);
        while (!req_ready) begin
            @(posedge clk); #1;
        end
        req_valid = 1; req_op = op; req_src_a = a; req_src_b = b; req_dst = d;
        expect_prog(op, a, b, d);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || busy) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    // Command sink: ready pattern changes just after each edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cmd_ready = stall_en ? lfsr[0] : 1'b1;
    end

    // Monitor: compare accepted commands, hold behaviour and done timing
    logic          prev_stall = 0;
    logic          prev_kind;
    logic [RW-1:0] prev_src, prev_dst;
    bit            want_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (want_done) begin
                check(done === 1'b1, "R10", "done after last accept", done, 1);
                want_done = 0;
            end else if (done) begin
                check(0, "R10", "unexpected done", done, 0);
            end
            if (prev_stall) begin
                check(cmd_valid && cmd_kind == prev_kind && cmd_src == prev_src
                      && cmd_dst == prev_dst, "R8", "held command src",
                      cmd_src, prev_src);
            end
            if (busy) begin
                check(!req_ready, "R9", "req_ready while busy", req_ready, 0);
            end
            if (cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "command with empty scoreboard", cmd_src, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cmd_kind == e.kind, e.tag, "cmd_kind", cmd_kind, e.kind);
                    check(cmd_src == e.src, e.tag, "cmd_src", cmd_src, e.src);
                    check(cmd_dst == e.dst, e.tag, "cmd_dst", cmd_dst, e.dst);
                    if (e.last) want_done = 1;
                end
            end
            prev_stall = cmd_valid && !cmd_ready;
            prev_kind = cmd_kind; prev_src = cmd_src; prev_dst = cmd_dst;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Main stimulus
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(!busy && !cmd_valid && !done && req_ready, "R1", "reset state",
              {busy, cmd_valid, done, req_ready}, 4'b0001);
        @(posedge clk); #1;

        send(3'd0, 10'd5, 10'd9, 10'd77);   drain();   // R2 AND
        send(3'd1, 10'd12, 10'd40, 10'd3);  drain();   // R3 OR
        send(3'd2, 10'd100, 10'd0, 10'd200); drain();  // R4 NOT
        send(3'd3, 10'd1, 10'd2, 10'd4);    drain();   // R5 NAND
        send(3'd4, 10'd8, 10'd16, 10'd32);  drain();   // R5 NOR
        send(3'd5, 10'd300, 10'd301, 10'd302); drain(); // R6 XOR
        send(3'd6, 10'd7, 10'd11, 10'd13);  drain();   // R11
        send(3'd7, 10'd17, 10'd19, 10'd23); drain();   // R11

        stall_en = 1;                                  // R8 backpressure
        send(3'd5, 10'd50, 10'd60, 10'd70); drain();
        send(3'd1, 10'd400, 10'd401, 10'd402); drain();
        send(3'd2, 10'd444, 10'd0, 10'd555); drain();

        // R9: request held high during a run must be ignored
        send(3'd4, 10'd20, 10'd21, 10'd22);
        req_valid = 1; req_op = 3'd2; req_src_a = 10'd999; req_dst = 10'd998;
        repeat (4) @(posedge clk);
        #1 req_valid = 0;
        drain();
        check(exp_q.size() == 0 && !busy, "R9", "no extra commands",
              exp_q.size(), 0);

        // R10: back-to-back requests, each with one done pulse
        stall_en = 0;
        send(3'd0, 10'd30, 10'd31, 10'd32);
        send(3'd2, 10'd33, 10'd0, 10'd34);
        drain();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule